// File: doc/BRIEF.md
# Filtered A12 Scanline Interrupt Counter

This block sits on the cartridge side of a video system. It counts scanlines by watching the pin-level A12 address line of the video chip and raises an interrupt request after a programmable number of lines. The A12 level is sampled on every CPU cycle. The block does not depend on seeing any CPU write to video registers, and it never looks at the video chip's internal scroll or address register. Bit 12 of that register follows the low bit of the fine vertical scroll, so it would advance the count only on every other line.

During rendering, A12 goes high briefly several times within one line, once for each pattern fetch. The block accepts a rising edge only after the line has been low for a minimum number of CPU cycles, set by `LOW_MIN`. With sprites in the upper pattern table and the background in the lower one, this leaves exactly one accepted tick per line. That tick comes from the first sprite fetch near dot 260.

Software programs a reload value. It can request a reload on the next tick, enable the interrupt, and acknowledge it. The acknowledge write also turns the interrupt off.

Top module: `a12_line_irq`

## Requirements
- R1: The counter reacts only to a low-to-high change of `a12_lvl` between two consecutive CPU-cycle samples. A falling edge, or a level held high or low for any length of time, never changes the count.
- R2: A rising edge is accepted only if the `LOW_MIN` samples just before it were all low (`LOW_MIN` = 8 by default). An edge after a shorter low run is ignored.
- R3: On an accepted tick, if the count is 0 or a reload request is pending, the count is loaded from the reload value and the pending request is cleared.
- R4: On an accepted tick with a nonzero count and no pending request, the count decreases by exactly one.
- R5: When an accepted tick leaves the count at 0 while the interrupt is enabled, `irq` goes to 1 at that same clock edge. It then stays at 1 until an acknowledge write.
- R6: A pulse on `wr_irq_off` drives `irq` to 0 on the next edge and disables the interrupt. Later zero counts do not raise `irq` until `wr_irq_on` is written again.
- R7: A pulse on `wr_irq_on` enables the interrupt and leaves an already-raised `irq` at 1.
- R8: An active-low `rst_n` clears the count, the reload value, the pending request, the enable, `irq` and the low-run filter.
- R9: Under the line fetch pattern (A12 high at dots 260–263, 268–271, …, 316–319 of each 341-dot line, sampled every 3 dots), exactly one tick is accepted per line. With a reload value of 240, `irq` is 0 after 240 lines and 1 after 241 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; one A12 sample per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a12_lvl | input | 1 | Pin-level A12 of the video chip, already synchronous to `clk` |
| wr_latch | input | 1 | Write strobe: store `wr_data` as the reload value |
| wr_data | input | CNT_W | Reload value written with `wr_latch` |
| wr_reload | input | 1 | Write strobe: request a reload on the next accepted tick |
| wr_irq_on | input | 1 | Write strobe: enable the interrupt |
| wr_irq_off | input | 1 | Write strobe: acknowledge and disable the interrupt |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with `CNT_W` = 8 and `LOW_MIN` = 8. An 8-bit count allows the reload of 240 that a full frame of 241 lines needs. A filter of 8 cycles lets low runs of 7 and 8 samples fall on either side of the acceptance threshold. The short gaps between the fetch pulses inside a line last one or two CPU samples, well under the threshold, so they show whether the filter suppresses the extra edges within a line.

// File: rtl/a12_line_irq_pkg.sv
package a12_line_irq_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_DEC  = 2'd2
  } cnt_act_e;

  // Selects what an incoming tick does to the counter.
  function automatic cnt_act_e pick_action(input logic tick,
                                           input logic is_zero,
                                           input logic reload_req);
    if (!tick)                    return ACT_HOLD;
    else if (is_zero || reload_req) return ACT_LOAD;
    else                          return ACT_DEC;
  endfunction

endpackage

// File: rtl/a12_rise_filter.sv
module a12_rise_filter #(
  parameter int LOW_MIN = 8,
  localparam int RUN_W  = $clog2(LOW_MIN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a12_lvl,
  output logic tick
);

  logic             a12_prev;
  logic [RUN_W-1:0] low_run;

  // Saturating increment of the low-run length.
  function automatic logic [RUN_W-1:0] run_step(input logic [RUN_W-1:0] r);
    if (int'(r) >= LOW_MIN) return r;
    else                    return r + 1'b1;
  endfunction

  function automatic logic run_long(input logic [RUN_W-1:0] r);
    return int'(r) >= LOW_MIN;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a12_prev <= 1'b0;
      low_run  <= '0;
    end else begin
      a12_prev <= a12_lvl;
      if (a12_lvl) low_run <= '0;
      else         low_run <= run_step(low_run);
    end
  end

  assign tick = a12_lvl & ~a12_prev & run_long(low_run);

endmodule

// File: rtl/a12_line_count.sv
module a12_line_count
  import a12_line_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_latch,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             wr_reload,
  output logic [CNT_W-1:0] count,
  output logic             reload_req,
  output logic             hit_zero
);

  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] count_nxt;
  cnt_act_e         act;

  always_comb begin
    act = pick_action(tick, count == '0, reload_req);
    unique case (act)
      ACT_LOAD: count_nxt = reload_val;
      ACT_DEC:  count_nxt = count - 1'b1;
      default:  count_nxt = count;
    endcase
  end

  assign hit_zero = tick && (count_nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count      <= '0;
      reload_val <= '0;
      reload_req <= 1'b0;
    end else begin
      count <= count_nxt;
      if (wr_latch) reload_val <= wr_data;
      if (act == ACT_LOAD) reload_req <= 1'b0;
      if (wr_reload)       reload_req <= 1'b1;
    end
  end

endmodule

// File: rtl/a12_irq_flag.sv
module a12_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_zero,
  input  logic wr_irq_on,
  input  logic wr_irq_off,
  output logic irq_en,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      irq    <= 1'b0;
    end else if (wr_irq_off) begin
      irq_en <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (wr_irq_on)          irq_en <= 1'b1;
      if (hit_zero && irq_en) irq    <= 1'b1;
    end
  end

endmodule

// File: rtl/a12_line_irq.sv
module a12_line_irq #(
  parameter int CNT_W   = 8,
  parameter int LOW_MIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a12_lvl,
  input  logic             wr_latch,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             wr_reload,
  input  logic             wr_irq_on,
  input  logic             wr_irq_off,
  output logic             irq
);

  logic             tick;
  logic             hit_zero;
  logic             reload_req;
  logic             irq_en;
  logic [CNT_W-1:0] count;

  a12_rise_filter #(.LOW_MIN(LOW_MIN)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .a12_lvl (a12_lvl),
    .tick    (tick)
  );

  a12_line_count #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_latch   (wr_latch),
    .wr_data    (wr_data),
    .wr_reload  (wr_reload),
    .count      (count),
    .reload_req (reload_req),
    .hit_zero   (hit_zero)
  );

  a12_irq_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_zero   (hit_zero),
    .wr_irq_on  (wr_irq_on),
    .wr_irq_off (wr_irq_off),
    .irq_en     (irq_en),
    .irq        (irq)
  );

endmodule

// File: rtl/a12_line_irq_chk.sv
module a12_line_irq_chk #(
  parameter int CNT_W   = 8,
  parameter int LOW_MIN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             a12_lvl,
  input logic             tick,
  input logic             reload_req,
  input logic             irq_en,
  input logic [CNT_W-1:0] count,
  input logic             wr_irq_on,
  input logic             wr_irq_off,
  input logic             irq
);

  // Independent low-run count kept by the checker itself.
  int seen_low;
  always_ff @(posedge clk) begin
    if (!rst_n)        seen_low <= 0;
    else if (a12_lvl)  seen_low <= 0;
    else if (seen_low < LOW_MIN) seen_low <= seen_low + 1;
  end

  p_tick_on_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> a12_lvl);

  p_tick_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (seen_low >= LOW_MIN));

  p_hold_without_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  p_load_clears_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reload_req) |=> !reload_req);

  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != '0 && !reload_req) |=> (count == $past(count) - 1'b1));

  p_raise_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (count == '0));

  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_irq_off) |=> irq);

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_irq_off |=> (!irq && !irq_en));

  p_enable_keeps_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_irq_on && !wr_irq_off && irq) |=> (irq && irq_en));

endmodule

bind a12_line_irq a12_line_irq_chk #(.CNT_W(CNT_W), .LOW_MIN(LOW_MIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .a12_lvl    (a12_lvl),
  .tick       (tick),
  .reload_req (reload_req),
  .irq_en     (irq_en),
  .count      (count),
  .wr_irq_on  (wr_irq_on),
  .wr_irq_off (wr_irq_off),
  .irq        (irq)
);

// File: tb/sim_a12_line_irq.sv
module sim_a12_line_irq;

  localparam int CNT_W   = 8;
  localparam int LOW_MIN = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             a12_lvl = 1'b0;
  logic             wr_latch = 1'b0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             wr_reload = 1'b0;
  logic             wr_irq_on = 1'b0;
  logic             wr_irq_off = 1'b0;
  logic             irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  a12_line_irq #(.CNT_W(CNT_W), .LOW_MIN(LOW_MIN)) u0 (
    .clk(clk), .rst_n(rst_n), .a12_lvl(a12_lvl),
    .wr_latch(wr_latch), .wr_data(wr_data), .wr_reload(wr_reload),
    .wr_irq_on(wr_irq_on), .wr_irq_off(wr_irq_off), .irq(irq)
  );

  // Vector table: optional acknowledge, low run, high run, expected irq.
  // Reload value is 2 and the interrupt is enabled before the walk.
  localparam int NV = 9;
  localparam int V_ACK [NV] = '{0, 0, 0, 0, 0, 1, 0, 0, 0};
  localparam int V_LOW [NV] = '{8, 7, 8, 3, 10, 8, 8, 8, 2};
  localparam int V_HIGH[NV] = '{4, 4, 20, 1, 4, 2, 3, 5, 30};
  localparam int V_IRQ [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0};
  localparam string V_TAG[NV] = '{"R3 load from zero", "R2 short low run",
    "R4 decrement, long high R1", "R2 glitch", "R5 reach zero",
    "R6 ack then load", "R4 decrement", "R6 zero while disabled",
    "R1 falling edge and static high"};

  task automatic check(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: irq=%0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    a12_lvl = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_latch(input logic [CNT_W-1:0] v);
    wr_latch = 1'b1; wr_data = v;
    @(negedge clk);
    wr_latch = 1'b0;
  endtask

  task automatic strobe_on();
    wr_irq_on = 1'b1; @(negedge clk); wr_irq_on = 1'b0;
  endtask

  task automatic strobe_off();
    wr_irq_off = 1'b1; @(negedge clk); wr_irq_off = 1'b0;
  endtask

  task automatic strobe_reload();
    wr_reload = 1'b1; @(negedge clk); wr_reload = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; a12_lvl = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R8 reset state", irq, 1'b0);

    // Table walk
    strobe_latch(8'd2);
    strobe_on();
    for (int i = 0; i < NV; i++) begin
      if (V_ACK[i] != 0) strobe_off();
      hold(1'b0, V_LOW[i]);
      hold(1'b1, V_HIGH[i]);
      check(V_TAG[i], irq, V_IRQ[i] != 0);
    end

    // R3: pending reload wins over decrement
    do_reset();
    strobe_latch(8'd5);
    strobe_on();
    hold(1'b0, 9); hold(1'b1, 2);          // 0 -> 5
    hold(1'b0, 9); hold(1'b1, 2);          // 5 -> 4
    strobe_latch(8'd1);
    strobe_reload();
    hold(1'b0, 9); hold(1'b1, 2);          // reload -> 1
    check("R3 reload request", irq, 1'b0);
    hold(1'b0, 9); hold(1'b1, 2);          // 1 -> 0
    check("R3 reload took effect, R5 raise", irq, 1'b1);

    // R7: enable write keeps raised irq
    strobe_on();
    check("R7 enable keeps irq", irq, 1'b1);
    hold(1'b0, 12);
    check("R5 irq sticky", irq, 1'b1);

    // R8: reset clears irq and reload value
    do_reset();
    check("R8 irq cleared by reset", irq, 1'b0);
    strobe_on();
    hold(1'b0, 9); hold(1'b1, 2);          // cleared reload 0 -> count 0
    check("R8 reload value cleared", irq, 1'b1);

    // R9: full frame of line fetch patterns
    do_reset();
    strobe_latch(8'd240);
    strobe_on();
    for (int c = 0; c < 27391; c++) begin
      int p;
      p = (3 * c) % 341;
      a12_lvl = (p >= 260 && p <= 319 && (((p - 260) / 4) % 2 == 0));
      @(negedge clk);
      if (c == 27313) check("R9 240 lines no irq", irq, 1'b0);
      if (c == 27390) check("R9 241 lines irq", irq, 1'b1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule